// File: doc/BRIEF.md
# On-Delay Timer

This block delays the rise of a boolean enable. While the input `in_i` stays high, an elapsed-time count `et_o` goes up by one on each cycle in which the time-base strobe `tick_i` is high. When the count reaches the preset `preset_i`, the output `q_o` rises. The output stays high until `in_i` falls, and the count stops moving in the meantime. A low `in_i` drops the timer back to idle and clears the count. The preset is a number of time-base ticks, so the real delay depends only on how often the surrounding logic pulses `tick_i`.

The block exposes a three-state view of its progress: idle, counting, fired. This lets properties be written on the sequence of states as well as on the count. A second way of working, selected by `abstract_i`, drops the count altogether. In that mode the step out of the counting state is taken whenever the external choice input `choice_i` is high. A testbench can then explore every possible firing moment without modelling time. Parameter `ABSTRACT_EN` = 0 builds the block without that mode, and `abstract_i` and `choice_i` are then ignored.

Top module: `ondelay_timer`

## Requirements
- R1: In timed mode (`abstract_i` low), while `in_i` is high and the timer has not fired, `et_o` rises by one on the clock after each cycle with `tick_i` high. It holds on cycles without a tick, and `q_o` stays low.
- R2: A cycle with `in_i` low makes `et_o` zero on the next clock edge.
- R3: In timed mode, the timer fires on the clock edge where the updated count equals or exceeds `preset_i`. Once fired, `et_o` keeps its value while `in_i` stays high, whatever `tick_i` and `preset_i` do.
- R4: `state_o` encodes idle as 0, counting as 1 and fired as 2. The value 3 never appears, and `q_o` is high exactly when `state_o` is 2.
- R5: In abstract mode, from the counting state, a high `choice_i` moves the timer to fired on the next edge. A low `choice_i` keeps it counting.
- R6: A cycle with `in_i` low sends the state to idle (0) on the next edge, from any state.
- R7: From idle, a cycle with `in_i` high leaves idle on the next edge. The timer goes to counting, or straight to fired when timed mode already reaches the preset.
- R8: In timed mode with `preset_i` = 0, the timer fires on the first edge at which `in_i` is sampled high.
- R9: In abstract mode, `et_o` is held at zero and `tick_i` and `preset_i` have no effect.
- R10: The reset is synchronous and active high. It leaves the state at idle, `et_o` at zero and `q_o` low.
- R11: If `preset_i` is lowered to or below the current count while counting, the count does not move. The timer fires on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| in_i | input | 1 | Timer enable |
| tick_i | input | 1 | Time-base strobe, one count per high cycle |
| preset_i | input | CNT_W | Preset in ticks |
| abstract_i | input | 1 | High selects abstract mode (choice-driven firing) |
| choice_i | input | 1 | Firing choice used in abstract mode |
| q_o | output | 1 | Delayed output, high when fired |
| et_o | output | CNT_W | Elapsed tick count |
| state_o | output | 2 | 0 idle, 1 counting, 2 fired |

## Verification
The properties assume that every input is synchronous to `clk_i` and settled at the rising edge. `preset_i`, `abstract_i` and `choice_i` may change on any cycle, even in the middle of a count, and the properties stay valid under such changes. The stimulus changes inputs only at the falling edge. It keeps the preset small, so that firing, firing with a zero preset, and lowering the preset below the count are all reached in a short run. It also switches between the two modes while `in_i` is high, not only from idle.

// File: rtl/ondelay_pkg.sv
package ondelay_pkg;
   typedef enum logic [1:0] {
      TMR_IDLE = 2'd0,
      TMR_RUN  = 2'd1,
      TMR_FIRE = 2'd2
   } tmr_state_e;
endpackage

// File: rtl/ondelay_mode_sel.sv
module ondelay_mode_sel #(
   parameter int ABSTRACT_EN = 1
) (
   input  logic abs_req_i,
   input  logic choice_req_i,
   output logic abs_o,
   output logic choice_o
);
   generate
      if (ABSTRACT_EN != 0) begin : g_abs_on
         assign abs_o    = abs_req_i;
         assign choice_o = choice_req_i;
      end else begin : g_abs_off
         logic unused_req;
         assign unused_req = abs_req_i ^ choice_req_i;
         assign abs_o      = 1'b0;
         assign choice_o   = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/ondelay_elapsed.sv
module ondelay_elapsed #(
   parameter int CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             clr_i,
   input  logic             hold_i,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] preset_i,
   output logic [CNT_W-1:0] et_o,
   output logic             reach_o
);
   logic [CNT_W-1:0] et_q;
   logic [CNT_W-1:0] et_nxt;
   logic             below;

   assign below = (et_q < preset_i);

   always_comb begin
      if (clr_i)
         et_nxt = '0;
      else if (!hold_i && tick_i && below)
         et_nxt = et_q + {{(CNT_W-1){1'b0}}, 1'b1};
      else
         et_nxt = et_q;
   end

   assign reach_o = (et_nxt >= preset_i);

   always_ff @(posedge clk_i) begin
      if (rst_i) et_q <= '0;
      else       et_q <= et_nxt;
   end

   assign et_o = et_q;
endmodule

// File: rtl/ondelay_fsm.sv
module ondelay_fsm
   import ondelay_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_i,
   input  logic       in_i,
   input  logic       abs_i,
   input  logic       choice_i,
   input  logic       reach_i,
   output tmr_state_e state_o
);
   tmr_state_e st_q, st_nxt;

   always_comb begin
      st_nxt = st_q;
      if (!in_i) begin
         st_nxt = TMR_IDLE;
      end else begin
         unique case (st_q)
            TMR_FIRE: st_nxt = TMR_FIRE;
            TMR_IDLE: begin
               if (abs_i) st_nxt = TMR_RUN;
               else       st_nxt = reach_i ? TMR_FIRE : TMR_RUN;
            end
            TMR_RUN: begin
               if (abs_i) st_nxt = choice_i ? TMR_FIRE : TMR_RUN;
               else       st_nxt = reach_i ? TMR_FIRE : TMR_RUN;
            end
            default:  st_nxt = TMR_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) st_q <= TMR_IDLE;
      else       st_q <= st_nxt;
   end

   assign state_o = st_q;
endmodule

// File: rtl/ondelay_timer.sv
module ondelay_timer
   import ondelay_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int ABSTRACT_EN = 1
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             in_i,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] preset_i,
   input  logic             abstract_i,
   input  logic             choice_i,
   output logic             q_o,
   output logic [CNT_W-1:0] et_o,
   output logic [1:0]       state_o
);
   generate
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_width
         $error("ondelay_timer: CNT_W must lie in 1..32");
      end
      if (ABSTRACT_EN != 0 && ABSTRACT_EN != 1) begin : g_bad_abs
         $error("ondelay_timer: ABSTRACT_EN must be 0 or 1");
      end
   endgenerate

   logic       abs_eff;
   logic       choice_eff;
   logic       reach;
   tmr_state_e st;

   ondelay_mode_sel #(.ABSTRACT_EN(ABSTRACT_EN)) u_mode (
      .abs_req_i    (abstract_i),
      .choice_req_i (choice_i),
      .abs_o        (abs_eff),
      .choice_o     (choice_eff)
   );

   ondelay_elapsed #(.CNT_W(CNT_W)) u_elapsed (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .clr_i    (!in_i || abs_eff),
      .hold_i   (st == TMR_FIRE),
      .tick_i   (tick_i),
      .preset_i (preset_i),
      .et_o     (et_o),
      .reach_o  (reach)
   );

   ondelay_fsm u_fsm (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .in_i     (in_i),
      .abs_i    (abs_eff),
      .choice_i (choice_eff),
      .reach_i  (reach),
      .state_o  (st)
   );

   assign state_o = st;
   assign q_o     = (st == TMR_FIRE);
endmodule

// File: rtl/ondelay_timer_chk.sv
module ondelay_timer_chk #(
   parameter int CNT_W       = 16,
   parameter int ABSTRACT_EN = 1
) (
   input logic             clk_i,
   input logic             rst_i,
   input logic             in_i,
   input logic             tick_i,
   input logic [CNT_W-1:0] preset_i,
   input logic             abstract_i,
   input logic             choice_i,
   input logic             q_o,
   input logic [CNT_W-1:0] et_o,
   input logic [1:0]       state_o
);
   logic abs_on;
   assign abs_on = (ABSTRACT_EN != 0) && abstract_i;

   logic unused_pt;
   assign unused_pt = ^preset_i;

   AST_IN_LOW_CLEARS_ET: assert property (@(posedge clk_i) disable iff (rst_i)
      !in_i |=> et_o == '0);  // R2
   AST_IN_LOW_IDLES: assert property (@(posedge clk_i) disable iff (rst_i)
      !in_i |=> state_o == 2'd0);  // R6
   AST_NO_TICK_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
      (in_i && !abs_on && state_o == 2'd1 && !tick_i) |=> et_o == $past(et_o));  // R1
   AST_FIRED_STAYS: assert property (@(posedge clk_i) disable iff (rst_i)
      (in_i && !abs_on && state_o == 2'd2) |=> (state_o == 2'd2 && $stable(et_o)));  // R3
   AST_LEGAL_STATE: assert property (@(posedge clk_i) disable iff (rst_i)
      state_o != 2'd3 && (q_o == (state_o == 2'd2)));  // R4
   AST_ABS_CHOICE: assert property (@(posedge clk_i) disable iff (rst_i)
      (in_i && abs_on && state_o == 2'd1) |=> state_o == ($past(choice_i) ? 2'd2 : 2'd1));  // R5
   AST_LEAVE_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
      (in_i && state_o == 2'd0) |=> state_o != 2'd0);  // R7
   AST_ABS_ET_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
      (in_i && abs_on) |=> et_o == '0);  // R9
   AST_TICK_ONLY_MOVES: assert property (@(posedge clk_i) disable iff (rst_i)
      (in_i && !tick_i) |=> et_o <= $past(et_o));  // R1
endmodule

bind ondelay_timer ondelay_timer_chk #(.CNT_W(CNT_W), .ABSTRACT_EN(ABSTRACT_EN)) u_chk (
   .clk_i      (clk_i),
   .rst_i      (rst_i),
   .in_i       (in_i),
   .tick_i     (tick_i),
   .preset_i   (preset_i),
   .abstract_i (abstract_i),
   .choice_i   (choice_i),
   .q_o        (q_o),
   .et_o       (et_o),
   .state_o    (state_o)
);

// File: tb/ondelay_timer_tb_top.sv
`timescale 1ns/1ps
module ondelay_timer_tb_top;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         in_s = 1'b0;
   logic         tick = 1'b0;
   logic [W-1:0] pt = '0;
   logic         abs_s = 1'b0;
   logic         ch = 1'b0;
   logic         q;
   logic [W-1:0] et;
   logic [1:0]   st;

   int    n_checks = 0;
   int    n_fail   = 0;
   string cur_req  = "R10";
   int    m_st = 0;
   int    m_et = 0;
   int    cyc  = 0;
   bit    done = 1'b0;

   always #5 clk = ~clk;

   ondelay_timer #(.CNT_W(W), .ABSTRACT_EN(1)) dut_i (
      .clk_i(clk), .rst_i(rst), .in_i(in_s), .tick_i(tick), .preset_i(pt),
      .abstract_i(abs_s), .choice_i(ch), .q_o(q), .et_o(et), .state_o(st)
   );

   // behavioural reference, advanced at every rising edge
   always @(posedge clk) begin
      if (rst) begin
         m_st = 0; m_et = 0;
      end else if (!in_s) begin
         m_st = 0; m_et = 0;
      end else if (abs_s) begin
         m_et = 0;
         if (m_st == 0)      m_st = 1;
         else if (m_st == 1) m_st = ch ? 2 : 1;
      end else if (m_st != 2) begin
         if (tick && m_et < int'(pt)) m_et = m_et + 1;
         m_st = (m_et >= int'(pt)) ? 2 : 1;
      end
   end

   task automatic check(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   always @(negedge clk) begin
      cyc++;
      if (!done) begin
         check(cur_req, "state", int'(st), m_st);
         check(cur_req, "et", int'(et), m_et);
         check("R4", "q", int'(q), (m_st == 2) ? 1 : 0);
      end
   end

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic drive(input bit i, input bit t, input int p, input bit a, input bit c);
      in_s = i; tick = t; pt = W'(p); abs_s = a; ch = c;
   endtask

   initial begin : watchdog
      #1000000;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin : stim
      logic [15:0] lfsr;
      // R10: reset state
      cur_req = "R10";
      drive(1, 1, 3, 0, 0);
      cycles(3);
      check("R10", "reset q", int'(q), 0);
      check("R10", "reset et", int'(et), 0);
      @(negedge clk); rst = 1'b0; drive(0, 0, 5, 0, 0);
      cycles(2);

      // R1/R3: count ticks every other cycle to preset 5
      cur_req = "R1";
      for (int i = 0; i < 12; i++) begin
         drive(1, i[0], 5, 0, 0);
         @(negedge clk);
      end
      check("R3", "fired et", int'(et), 5);
      check("R3", "fired q", int'(q), 1);
      cur_req = "R3";
      drive(1, 1, 9, 0, 0);   // raised preset and ticks while fired
      cycles(4);
      check("R3", "frozen et", int'(et), 5);

      // R2/R6: drop enable from fired
      cur_req = "R6";
      drive(0, 1, 9, 0, 0);
      cycles(1);
      check("R2", "cleared et", int'(et), 0);
      check("R6", "idle state", int'(st), 0);

      // R8: zero preset
      cur_req = "R8";
      drive(1, 0, 0, 0, 0);
      cycles(1);
      check("R8", "zero preset fires", int'(st), 2);
      drive(0, 0, 0, 0, 0); cycles(1);

      // R7 plus preset 1 with tick on first cycle
      cur_req = "R7";
      drive(1, 1, 1, 0, 0);
      cycles(1);
      check("R7", "direct fire", int'(st), 2);
      drive(0, 0, 1, 0, 0); cycles(1);

      // R11: lower preset beneath count
      cur_req = "R11";
      drive(1, 1, 10, 0, 0); cycles(4);
      drive(1, 0, 2, 0, 0); cycles(1);
      check("R11", "fires after lower", int'(st), 2);
      check("R11", "count kept", int'(et), 4);
      drive(0, 0, 2, 0, 0); cycles(1);

      // R5/R7/R9: abstract mode
      cur_req = "R5";
      drive(1, 1, 3, 1, 0); cycles(1);
      check("R7", "abs leaves idle", int'(st), 1);
      drive(1, 1, 3, 1, 0); cycles(5);
      check("R9", "abs et zero", int'(et), 0);
      check("R5", "abs stays counting", int'(st), 1);
      drive(1, 1, 3, 1, 1); cycles(1);
      check("R5", "abs fires", int'(st), 2);
      cur_req = "R9";
      drive(1, 1, 0, 1, 0); cycles(3);
      check("R9", "abs fired et", int'(et), 0);
      drive(0, 0, 0, 1, 0); cycles(1);

      // mixed pseudo-random stimulus
      cur_req = "R4";
      lfsr = 16'hACE1;
      for (int i = 0; i < 600; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         drive(lfsr[0] | lfsr[1] | lfsr[2], lfsr[3], int'(lfsr[6:4]),
               lfsr[7] & lfsr[8] & lfsr[9], lfsr[11]);
         @(negedge clk);
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule